// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synchronous, single-port, common-I/O static memory with registered inputs and a registered read path. It has a small word array whose depth is a parameter. It decides on every rising clock edge whether the cycle is a read, a write, a deselect or the continuation of an open burst. There are two start strobes. The processor strobe always opens an access as a read, and it writes on the following edge. The controller strobe can write on the same edge that captures the address. Writes use four 8-bit lanes and can be global or per byte.

Read data leaves an output register one clock after the address is taken. The bidirectional bus is shown as a data-out word and an output-enable bit. The enable is forced off during writes, during the first cycle after the memory is re-selected, and right after a deselect. The next address within a burst comes from an external sequence generator. The block shows that generator its current address and takes the generator's next address back in.

Top module: `pbsram_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no access issued, `dout_en` is 0.
- R2: When an access reads address A at a rising edge, `dout` holds word A after the next rising edge. A read edge is one where a start strobe is low, all three selects are active and `gw_n` and `bwe_n` are both high.
- R3: `proc_stb_n` has no effect while `cs1_n` is high. It neither starts nor deselects. With `ctrl_stb_n` high, the open access continues on its captured address.
- R4: A processor-strobe start treats the edge as a read and ignores all write inputs. Write inputs present on the next edge write `din` to the access address.
- R5: A controller-strobe start with `proc_stb_n` high, the chip selected and `gw_n` or `bwe_n` low writes `din` at that same edge.
- R6: With `gw_n` low, all four lanes are written. Otherwise lane i (bits 8i+7..8i) is written only when `bwe_n` is low and `bw_n[i]` is low. Unwritten lanes keep their value.
- R7: `dout_en` is 0 during any cycle whose write inputs cause a write, and during the cycle after that write edge.
- R8: In the cycle after an access starts from the deselected state, `dout_en` is 0.
- R9: At an edge where a start strobe is low and the chip is not selected, the block enters the deselected state, and `dout_en` is 0 right after that edge.
- R10: `oe_n` gates `dout_en` combinationally. Setting `oe_n` high drops `dout_en` with no clock edge.
- R11: With both start strobes inactive during an open access, the access continues. `adv_n` low selects `burst_addr` as the address. `adv_n` high keeps the captured address. The write inputs are sampled on every such cycle.
- R12: `cur_addr` shows the address of the most recent access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Start address |
| proc_stb_n | input | 1 | Processor start strobe, active low |
| ctrl_stb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates proc_stb_n |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 8*LANES | Write data |
| burst_addr | input | AW | Next burst address from the sequence generator |
| dout | output | 8*LANES | Registered read data |
| dout_en | output | 1 | Bus driver enable |
| cur_addr | output | AW | Address of the current access |

## Verification
The processor-strobe write overlaps with the read pipeline. On its second edge, the read data from the first edge is loading into the output register at the same moment as the write lands. The bench sets up this collision. It checks that the bus enable stays low through the write cycle and the cycle after it. It then reads the word back and compares it lane by lane against a model in which the junk data offered on the first edge was never stored. A second collision is a burst continuation that writes one word while the pipeline still carries the previous word's read. This is judged by the enable and by readback of both addresses.

// File: rtl/pbsram_ctl.sv
module pbsram_ctl #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             proc_stb_n,
  input  logic             ctrl_stb_n,
  input  logic             adv_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  input  logic [AW-1:0]    burst_addr,
  output logic [DW-1:0]    dout,
  output logic             dout_en,
  output logic [AW-1:0]    cur_addr
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [AW-1:0] aq;
  logic          act_q, pend_q, drv_q;

  wire sel     = !cs1_n && cs2 && !cs3_n;
  wire p_go    = !proc_stb_n && !cs1_n;
  wire start   = p_go || !ctrl_stb_n;
  wire new_acc = start && sel;
  wire desel   = start && !sel;
  wire cont    = !start && act_q;
  wire acc     = new_acc || cont;
  wire wr_req  = !gw_n || !bwe_n;
  wire wr_now  = (new_acc && !p_go && wr_req) || (cont && wr_req);
  wire [LANES-1:0] lane_we = gw_n ? ({LANES{!bwe_n}} & ~bw_n) : {LANES{1'b1}};
  wire [AW-1:0] acc_a = new_acc ? addr : (adv_n ? aq : burst_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      drv_q  <= 1'b0;
      rd_q   <= '0;
      aq     <= '0;
    end else begin
      drv_q  <= pend_q && !desel && !wr_now;
      pend_q <= acc && !wr_now;
      if (pend_q) rd_q <= mem[aq];
      if (desel) act_q <= 1'b0;
      else if (new_acc) act_q <= 1'b1;
      if (acc) aq <= acc_a;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_now && lane_we[i]) mem[acc_a][8*i +: 8] <= din[8*i +: 8];
  end

  assign dout     = rd_q;
  assign dout_en  = drv_q && !oe_n && !wr_now;
  assign cur_addr = aq;

  AST_DESEL_HIZ:  assert property (@(posedge clk) disable iff (!rst_n) desel |=> !dout_en); // R9
  AST_FIRST_HIZ:  assert property (@(posedge clk) disable iff (!rst_n) (new_acc && !act_q) |=> !dout_en); // R8
  AST_WR_HIZ:     assert property (@(posedge clk) disable iff (!rst_n) wr_now |=> !dout_en); // R7
  AST_PSTB_NOWR:  assert property (@(posedge clk) disable iff (!rst_n)
                    (new_acc && p_go) |=> mem[$past(addr)] === $past(mem[addr])); // R4
  AST_LANE_KEEP:  assert property (@(posedge clk) disable iff (!rst_n)
                    (new_acc && !p_go && wr_req && gw_n && bw_n[0]) |=> mem[$past(addr)][7:0] === $past(mem[addr][7:0])); // R6
  AST_HOLD_ADDR:  assert property (@(posedge clk) disable iff (!rst_n)
                    (cont && adv_n) |=> cur_addr == $past(cur_addr)); // R11

endmodule

// File: tb/test_pbsram_ctl.sv
module test_pbsram_ctl;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0, burst_addr = '0;
  logic proc_stb_n, ctrl_stb_n, adv_n, cs1_n, cs2, cs3_n, gw_n, bwe_n, oe_n;
  logic [3:0] bw_n;
  logic [31:0] din = '0;
  logic [31:0] dout;
  logic dout_en;
  logic [AW-1:0] cur_addr;
  logic [31:0] mdl [DEPTH];
  int n = 0, err = 0;

  // vector: {addr, gw_n, bwe_n, bw_n, data}
  localparam logic [41:0] VEC [0:7] = '{
    {4'd1,  1'b0, 1'b1, 4'hF, 32'hA5A5_0001},
    {4'd2,  1'b1, 1'b0, 4'b1110, 32'h0000_00C3},
    {4'd3,  1'b1, 1'b0, 4'b0101, 32'h7788_99AA},
    {4'd7,  1'b1, 1'b0, 4'b0000, 32'hCAFE_F00D},
    {4'd11, 1'b1, 1'b0, 4'b0111, 32'hEE00_0000},
    {4'd12, 1'b0, 1'b0, 4'b1111, 32'h1357_9BDF},
    {4'd13, 1'b1, 1'b0, 4'b1111, 32'hFFFF_FFFF},
    {4'd15, 1'b1, 1'b0, 4'b1001, 32'h0BAD_BE00}
  };

  always #10 clk = ~clk;

  pbsram_ctl #(.DEPTH(DEPTH), .LANES(4)) i_pbsram_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .proc_stb_n(proc_stb_n),
    .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .din(din), .burst_addr(burst_addr), .dout(dout), .dout_en(dout_en),
    .cur_addr(cur_addr));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic rest();
    proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bw_n = 4'hF;
    cs1_n = 0; cs2 = 1; cs3_n = 0; oe_n = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mupd(input logic [AW-1:0] a, input logic [31:0] d, input logic g,
                      input logic be, input logic [3:0] bw);
    for (int i = 0; i < 4; i++)
      if (!g || (!be && !bw[i])) mdl[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic desel_edge();
    rest(); ctrl_stb_n = 0; cs3_n = 1;
    tick();
    chk("R9 deselect hiz", {31'd0, dout_en}, 32'd0);
    rest();
  endtask

  task automatic cwrite(input logic [AW-1:0] a, input logic [31:0] d, input logic g,
                        input logic be, input logic [3:0] bw);
    rest(); addr = a; din = d; gw_n = g; bwe_n = be; bw_n = bw; ctrl_stb_n = 0;
    #1 chk("R7 write cycle hiz", {31'd0, dout_en}, 32'd0);
    tick();
    mupd(a, d, g, be, bw);
    rest();
    #1 chk("R7 after write hiz", {31'd0, dout_en}, 32'd0);
    desel_edge();
  endtask

  task automatic cread(input string r, input logic [AW-1:0] a);
    rest(); addr = a; ctrl_stb_n = 0;
    tick();
    rest();
    #1 chk("R8 first cycle hiz", {31'd0, dout_en}, 32'd0);
    chk("R12 cur_addr", {28'd0, cur_addr}, {28'd0, a});
    tick();
    chk(r, dout, mdl[a]);
    chk("R2 read enable", {31'd0, dout_en}, 32'd1);
    desel_edge();
  endtask

  initial begin
    rest();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset hiz", {31'd0, dout_en}, 32'd0);
    rst_n = 1;
    tick();
    chk("R1 after reset hiz", {31'd0, dout_en}, 32'd0);

    for (int i = 0; i < DEPTH; i++) cwrite(i[AW-1:0], 32'h5000_0000 + 32'(i) * 32'h0101_0101, 1'b0, 1'b1, 4'hF);
    cread("R2 preload read", 4'd0);

    // R5 R6 table
    for (int i = 0; i < 8; i++) begin
      cwrite(VEC[i][41:38], VEC[i][31:0], VEC[i][37], VEC[i][36], VEC[i][35:32]);
      cread("R5 R6 lane readback", VEC[i][41:38]);
    end
    cread("R6 untouched neighbour", 4'd14);

    // R10 combinational oe_n
    rest(); addr = 4'd3; ctrl_stb_n = 0; tick();
    rest(); tick();
    chk("R10 driven", {31'd0, dout_en}, 32'd1);
    oe_n = 1; #1 chk("R10 oe_n high", {31'd0, dout_en}, 32'd0);
    oe_n = 0; #1 chk("R10 oe_n low", {31'd0, dout_en}, 32'd1);
    desel_edge();

    // R3 processor strobe ignored with cs1_n high
    rest(); addr = 4'd2; ctrl_stb_n = 0; tick();
    rest(); proc_stb_n = 0; cs1_n = 1; addr = 4'd7; tick();
    chk("R3 still reading", dout, mdl[2]);
    chk("R3 still driven", {31'd0, dout_en}, 32'd1);
    chk("R3 address kept", {28'd0, cur_addr}, 32'd2);
    desel_edge();

    // R4 processor-strobe write, two edges
    rest(); addr = 4'd6; proc_stb_n = 0; gw_n = 0; din = 32'hDEAD_BEEF; tick();
    rest(); bwe_n = 0; bw_n = 4'b1010; din = 32'h1122_3344;
    #1 chk("R7 proc write cycle hiz", {31'd0, dout_en}, 32'd0);
    tick();
    mupd(4'd6, 32'h1122_3344, 1'b1, 1'b0, 4'b1010);
    rest();
    #1 chk("R7 after proc write hiz", {31'd0, dout_en}, 32'd0);
    desel_edge();
    cread("R4 proc write readback", 4'd6);

    // R11 burst continuation write with advance
    rest(); addr = 4'd4; ctrl_stb_n = 0; tick();
    rest(); adv_n = 0; burst_addr = 4'd5; gw_n = 0; din = 32'h0F1E_2D3C; tick();
    mdl[5] = 32'h0F1E_2D3C;
    chk("R11 advanced address", {28'd0, cur_addr}, 32'd5);
    desel_edge();
    cread("R11 burst write readback", 4'd5);
    cread("R11 start word intact", 4'd4);

    // R11 burst read, consecutive words
    rest(); addr = 4'd8; ctrl_stb_n = 0; tick();
    rest(); adv_n = 0; burst_addr = 4'd9; tick();
    chk("R2 burst first word", dout, mdl[8]);
    rest(); tick();
    chk("R11 burst second word", dout, mdl[9]);
    chk("R11 held address", {28'd0, cur_addr}, 32'd9);
    desel_edge();

    $display("Result: errors=%0d of %0d checks", err, n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n++; err++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", err, n);
    $finish;
  end
endmodule